// File: doc/BRIEF.md
# NAND Command and Address Front-End

This block sits between a simple host register port and one 8-bit NAND flash device. Host writes to a command register, an address register and a data register each become exactly one strobed bus cycle on the NAND pins. Command cycles raise the command latch line and address cycles raise the address latch line. The write strobe is held low for a fixed number of clocks and then released for a fixed number of hold clocks. A host read of the data register runs one read-strobe cycle and returns the byte the device drove.

The address sequence is closed by a flag bit in the final address write, and the controller remembers whether an address sequence is still open. Device readiness is reported as a sticky flag. The flag is set when the synchronised ready/busy line goes ready and stays set until the host writes a one to it; the flag is also driven out as an interrupt line. A control register holds the chip-select disable bit and a self-clearing soft-reset bit. A second control register drives the write-protect pin. The strobe timing is fixed by parameters.

Top module: `nfe_top`

## Requirements
- R1: A write to the command register (select 2) runs one command cycle. CLE is high, ALE is low, the write strobe is low for WE_LOW_CYC clocks and then high for WE_HOLD_CYC clocks, and the bus carries bits 7:0 of the write data. Higher data bits have no effect.
- R2: Each write to the address register (select 3) runs one address cycle with ALE high and CLE low, carrying bits 7:0. Bit 31 set in that write closes the address sequence. Bit 31 clear leaves it open. Reading select 3 returns the open state in bit 0.
- R3: Outside a command or address cycle, CLE and ALE are low. They are never high together, and both drop in the clock after the strobe hold time ends.
- R4: A write to select 2, 3 or 4 that arrives while a bus cycle runs is held with host_stall until the bus is idle, and is then carried out in full. For a write arriving in the first strobe clock, the stall lasts WE_LOW_CYC+WE_HOLD_CYC clocks.
- R5: A write to the data register (select 4) runs one data cycle with CLE and ALE low and bits 7:0 driven onto the bus with nand_dq_oe high.
- R6: A read of select 4 holds the read strobe low for RE_LOW_CYC clocks and then high for RE_HOLD_CYC clocks, with the bus not driven. The host stalls until the cycle ends and then receives in bits 7:0 the byte sampled at the rising read strobe. Later changes on the bus do not alter the returned byte.
- R7: Bit 10 of the flag register (select 1) and ready_irq are set when the synchronised ready/busy input rises. The flag stays set through later falls of that input.
- R8: Writing 1 to bit 10 of select 1 clears the flag. Writing 0 there leaves it set.
- R9: Bit 25 of the control register (select 0) set drives nand_ce_n high. Bit 25 clear drives it low.
- R10: Bit 0 of the pin control register (select 5) drives nand_wp_n: 1 releases protection (high) and 0 asserts it (low).
- R11: A control write with bit 0 set aborts any bus cycle, so all strobes and latch lines are idle in the next clock. It also closes the address sequence. The next command then runs normally.
- R12: After reset: nand_ce_n high, nand_we_n and nand_re_n high, CLE and ALE low, nand_wp_n low, nand_dq_oe low, ready_irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_rd is high and host_stall is low |
| host_stall | output | 1 | Request must be held |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_out | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| ready_irq | output | 1 | Sticky ready flag |

## Verification
The properties assume the host never raises host_wr and host_rd together. They also assume that a stalled request is held unchanged until host_stall drops. The ready/busy input may change at any time because it passes through a synchroniser. The bench issues one request at a time from tasks that keep the request asserted until it is accepted. The bench starts a data read only after its pin model shows the bus idle, and it changes the ready line and the bus byte only on falling clock edges.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_FLAG = 3'd1,
    SEL_CMD  = 3'd2,
    SEL_ADDR = 3'd3,
    SEL_DATA = 3'd4,
    SEL_PINS = 3'd5
  } nfe_sel_e;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WDAT = 2'd2,
    K_RDAT = 2'd3
  } nfe_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HOLD = 2'd2
  } nfe_phase_e;

  localparam int SRST_BIT      = 0;
  localparam int RDY_BIT       = 10;
  localparam int CS_OFF_BIT    = 25;
  localparam int LAST_ADDR_BIT = 31;
  localparam int WP_REL_BIT    = 0;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // counter load value so that a phase lasts exactly len clocks
  function automatic int phase_load(input int len);
    return len - 1;
  endfunction

  function automatic nfe_kind_e kind_of_sel(input nfe_sel_e s);
    case (s)
      SEL_CMD:  return K_CMD;
      SEL_ADDR: return K_ADDR;
      default:  return K_WDAT;
    endcase
  endfunction

endpackage

// File: rtl/nfe_strobe_seq.sv
module nfe_strobe_seq
  import nfe_pkg::*;
#(
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HOLD_CYC = 1,
  parameter int RE_LOW_CYC  = 3,
  parameter int RE_HOLD_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       start,
  input  nfe_kind_e  kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] dq_in,
  output logic       busy,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic [7:0] rbyte,
  output logic       rd_fin
);
  localparam int MAXT  = max4(WE_LOW_CYC, WE_HOLD_CYC, RE_LOW_CYC, RE_HOLD_CYC);
  localparam int CNT_W = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [CNT_W-1:0] WLO_LD = CNT_W'(phase_load(WE_LOW_CYC));
  localparam logic [CNT_W-1:0] WHI_LD = CNT_W'(phase_load(WE_HOLD_CYC));
  localparam logic [CNT_W-1:0] RLO_LD = CNT_W'(phase_load(RE_LOW_CYC));
  localparam logic [CNT_W-1:0] RHI_LD = CNT_W'(phase_load(RE_HOLD_CYC));

  nfe_phase_e       ph_q;
  nfe_kind_e        kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       byte_q;
  logic [7:0]       rbyte_q;
  logic             is_rd;
  logic             cnt_end;

  assign is_rd   = (kind_q == K_RDAT);
  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      kind_q  <= K_CMD;
      cnt_q   <= '0;
      byte_q  <= '0;
      rbyte_q <= '0;
    end else if (soft_rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q   <= PH_LOW;
            kind_q <= kind;
            byte_q <= wbyte;
            cnt_q  <= (kind == K_RDAT) ? RLO_LD : WLO_LD;
          end
        end
        PH_LOW: begin
          if (cnt_end) begin
            ph_q  <= PH_HOLD;
            cnt_q <= is_rd ? RHI_LD : WHI_LD;
            if (is_rd) rbyte_q <= dq_in;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_end) ph_q <= PH_IDLE;
          else         cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (ph_q != PH_IDLE);
  assign cle    = busy && (kind_q == K_CMD);
  assign ale    = busy && (kind_q == K_ADDR);
  assign we_n   = !((ph_q == PH_LOW) && !is_rd);
  assign re_n   = !((ph_q == PH_LOW) && is_rd);
  assign dq_oe  = busy && !is_rd;
  assign dq_out = byte_q;
  assign rbyte  = rbyte_q;
  assign rd_fin = (ph_q == PH_HOLD) && cnt_end && is_rd;
endmodule

// File: rtl/nfe_rdy_flag.sv
module nfe_rdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_in,
  input  logic clr,
  output logic rise,
  output logic flag
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rb_in};
  end

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (rise) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/nfe_top.sv
module nfe_top
  import nfe_pkg::*;
#(
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HOLD_CYC = 1,
  parameter int RE_LOW_CYC  = 3,
  parameter int RE_HOLD_CYC = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_stall,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb,
  output logic        ready_irq
);
  nfe_sel_e  sel;
  nfe_kind_e kind;
  logic      is_bus_sel, wr_bus, rd_data, wr_go, rd_go, start;
  logic      bus_busy, rd_fin, rd_done_q;
  logic      cs_off_q, wp_rel_q, addr_open_q;
  logic      evt_soft_rst, evt_ctrl_wr, evt_flag_clr, evt_rb_rise;
  logic [7:0] rbyte;
  logic      unused_wdata;

  assign sel        = nfe_sel_e'(host_sel);
  assign is_bus_sel = (sel == SEL_CMD) || (sel == SEL_ADDR) || (sel == SEL_DATA);
  assign wr_bus     = host_wr && is_bus_sel;
  assign rd_data    = host_rd && (sel == SEL_DATA);
  assign wr_go      = wr_bus && !bus_busy;
  assign rd_go      = rd_data && !bus_busy && !rd_done_q;
  assign start      = wr_go || rd_go;
  assign kind       = rd_go ? K_RDAT : kind_of_sel(sel);
  assign host_stall = (wr_bus && bus_busy) || (rd_data && !rd_done_q);

  assign evt_ctrl_wr  = host_wr && (sel == SEL_CTRL);
  assign evt_soft_rst = evt_ctrl_wr && host_wdata[SRST_BIT];
  assign evt_flag_clr = host_wr && (sel == SEL_FLAG) && host_wdata[RDY_BIT];

  assign unused_wdata = ^{host_wdata[30:26], host_wdata[24:11], host_wdata[9:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_off_q    <= 1'b1;
      wp_rel_q    <= 1'b0;
      addr_open_q <= 1'b0;
      rd_done_q   <= 1'b0;
    end else begin
      if (evt_ctrl_wr) cs_off_q <= host_wdata[CS_OFF_BIT];
      if (host_wr && (sel == SEL_PINS)) wp_rel_q <= host_wdata[WP_REL_BIT];
      if (evt_soft_rst)
        addr_open_q <= 1'b0;
      else if (wr_go && (sel == SEL_ADDR))
        addr_open_q <= !host_wdata[LAST_ADDR_BIT];
      if (evt_soft_rst)
        rd_done_q <= 1'b0;
      else if (rd_fin)
        rd_done_q <= 1'b1;
      else if (rd_data && rd_done_q)
        rd_done_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (sel)
      SEL_CTRL: host_rdata[CS_OFF_BIT] = cs_off_q;
      SEL_FLAG: host_rdata[RDY_BIT]    = ready_irq;
      SEL_ADDR: host_rdata[0]          = addr_open_q;
      SEL_DATA: host_rdata[7:0]        = rbyte;
      SEL_PINS: host_rdata[WP_REL_BIT] = wp_rel_q;
      default:  host_rdata = '0;
    endcase
  end

  nfe_strobe_seq #(
    .WE_LOW_CYC (WE_LOW_CYC),
    .WE_HOLD_CYC(WE_HOLD_CYC),
    .RE_LOW_CYC (RE_LOW_CYC),
    .RE_HOLD_CYC(RE_HOLD_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(evt_soft_rst),
    .start   (start),
    .kind    (kind),
    .wbyte   (host_wdata[7:0]),
    .dq_in   (nand_dq_in),
    .busy    (bus_busy),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .dq_out  (nand_dq_out),
    .dq_oe   (nand_dq_oe),
    .rbyte   (rbyte),
    .rd_fin  (rd_fin)
  );

  nfe_rdy_flag u_rdy (
    .clk  (clk),
    .rst_n(rst_n),
    .rb_in(nand_rb),
    .clr  (evt_flag_clr),
    .rise (evt_rb_rise),
    .flag (ready_irq)
  );

  assign nand_ce_n = cs_off_q;
  assign nand_wp_n = wp_rel_q;
endmodule

// File: rtl/nfe_chk.sv
module nfe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_req,
  input logic       evt_ctrl_wr,
  input logic       evt_soft_rst,
  input logic       evt_flag_clr,
  input logic       evt_rb_rise,
  input logic       bus_busy,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe,
  input logic [7:0] nand_dq_out,
  input logic       ready_irq
);
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_read_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_we_has_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> (nand_cle || nand_ale || nand_dq_oe));

  p_dq_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  p_no_new_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (!$fell(nand_we_n) && !$fell(nand_re_n)));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rb_rise |=> ready_irq);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_irq && !evt_flag_clr) |=> ready_irq);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag_clr && !evt_rb_rise) |=> !ready_irq);

  p_soft_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_soft_rst |=> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));

  p_ce_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ctrl_wr |=> (nand_ce_n == $past(cs_req)));
endmodule

bind nfe_top nfe_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_req      (host_wdata[25]),
  .evt_ctrl_wr (evt_ctrl_wr),
  .evt_soft_rst(evt_soft_rst),
  .evt_flag_clr(evt_flag_clr),
  .evt_rb_rise (evt_rb_rise),
  .bus_busy    (bus_busy),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_dq_oe  (nand_dq_oe),
  .nand_dq_out (nand_dq_out),
  .ready_irq   (ready_irq)
);

// File: tb/nfe_top_tb.sv
`timescale 1ns/1ps
module nfe_top_tb_top;
  localparam int WLO = 2;
  localparam int WHI = 1;
  localparam int RLO = 3;
  localparam int RHI = 1;
  localparam logic [2:0] S_CTRL = 3'd0, S_FLAG = 3'd1, S_CMD = 3'd2,
                         S_ADDR = 3'd3, S_DATA = 3'd4, S_PINS = 3'd5;
  localparam logic [12:0] IDLE_V = {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_sel = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_stall;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;
  logic        ready_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic [12:0] exp_q[$];

  int n_cmd = 0, n_addr = 0, n_wd = 0;
  logic [7:0] last_cmd = '0, last_addr = '0, last_wd = '0;
  logic prev_we = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0;
  logic [7:0] prev_dq = '0;

  always #2 clk = ~clk;

  nfe_top #(.WE_LOW_CYC(WLO), .WE_HOLD_CYC(WHI), .RE_LOW_CYC(RLO), .RE_HOLD_CYC(RHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_stall(host_stall),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb), .ready_irq(ready_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference pin model: one expected pin vector per clock
  always @(negedge clk) begin
    logic [12:0] e;
    logic [12:0] a;
    if (mon_on) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
      a = {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe,
           nand_dq_oe ? nand_dq_out : 8'h00};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL R3 pin sequence at cycle %0d act=%h exp=%h", cyc, a, e);
      end
      if (!prev_we && nand_we_n) begin
        if (prev_cle) begin n_cmd++; last_cmd = prev_dq; end
        else if (prev_ale) begin n_addr++; last_addr = prev_dq; end
        else begin n_wd++; last_wd = prev_dq; end
      end
      prev_we  = nand_we_n;
      prev_cle = nand_cle;
      prev_ale = nand_ale;
      prev_dq  = nand_dq_out;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_w(input logic c, input logic a, input logic [7:0] d);
    for (int i = 0; i < WLO; i++) exp_q.push_back({c, a, 1'b0, 1'b1, 1'b1, d});
    for (int i = 0; i < WHI; i++) exp_q.push_back({c, a, 1'b1, 1'b1, 1'b1, d});
  endtask

  task automatic push_r();
    for (int i = 0; i < RLO; i++) exp_q.push_back({1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00});
    for (int i = 0; i < RHI; i++) exp_q.push_back({1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00});
  endtask

  task automatic bus_wr(input logic [2:0] sel, input logic [31:0] d, output int stalls);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    #1;
    stalls = 0;
    while (host_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    host_wr = 1'b0;
    if (sel == S_CMD) push_w(1'b1, 1'b0, d[7:0]);
    else if (sel == S_ADDR) push_w(1'b0, 1'b1, d[7:0]);
    else if (sel == S_DATA) push_w(1'b0, 1'b0, d[7:0]);
    else if (sel == S_CTRL && d[0]) exp_q.delete();
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic bus_rd(input logic [2:0] sel, input bit swap, input logic [7:0] alt,
                        output logic [31:0] d);
    if (sel == S_DATA) begin
      while (exp_q.size() != 0) @(posedge clk);
      @(negedge clk);
      host_sel = sel; host_rd = 1'b1;
      @(posedge clk);
      push_r();
      repeat (RLO) @(posedge clk);
      #1;
      if (swap) nand_dq_in = alt;
      @(negedge clk);
      #1;
      while (host_stall) begin
        @(negedge clk);
        #1;
      end
      d = host_rdata;
    end else begin
      @(negedge clk);
      host_sel = sel; host_rd = 1'b1;
      #1;
      d = host_rdata;
    end
    @(posedge clk);
    #1;
    host_rd = 1'b0;
  endtask

  initial begin
    int s;
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 reset pins", {24'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale,
        nand_wp_n, nand_dq_oe, ready_irq}, {24'h0, 8'b1110_0000});
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R9 chip select
    bus_wr(S_CTRL, 32'h0200_0000, s);
    chk("R9 ce_n with disable bit set", {31'h0, nand_ce_n}, 32'h1);
    bus_rd(S_CTRL, 1'b0, 8'h00, r);
    chk("R9 control readback", r, 32'h0200_0000);
    bus_wr(S_CTRL, 32'h0, s);
    chk("R9 ce_n enabled", {31'h0, nand_ce_n}, 32'h0);

    // R10 write protect
    bus_wr(S_PINS, 32'h1, s);
    chk("R10 wp released", {31'h0, nand_wp_n}, 32'h1);
    bus_wr(S_PINS, 32'h0, s);
    chk("R10 wp asserted", {31'h0, nand_wp_n}, 32'h0);
    bus_wr(S_PINS, 32'h1, s);

    // R1 command cycle, upper data bits ignored
    bus_wr(S_CMD, 32'hFFFF_FF90, s);
    wait_idle();
    chk("R1 command count", n_cmd, 1);
    chk("R1 command opcode", {24'h0, last_cmd}, 32'h90);

    // R2 address sequence
    bus_wr(S_ADDR, 32'h0000_0012, s);
    bus_rd(S_ADDR, 1'b0, 8'h00, r);
    chk("R2 address phase open", r, 32'h1);
    bus_wr(S_ADDR, 32'h0000_0034, s);
    bus_wr(S_ADDR, 32'h8000_0056, s);
    bus_rd(S_ADDR, 1'b0, 8'h00, r);
    chk("R2 address phase closed by bit 31", r, 32'h0);
    wait_idle();
    chk("R2 address count", n_addr, 3);
    chk("R2 last address byte", {24'h0, last_addr}, 32'h56);

    // R4 back-to-back commands stall
    bus_wr(S_CMD, 32'h00, s);
    bus_wr(S_CMD, 32'h30, s);
    chk("R4 stall length", s, WLO + WHI);
    wait_idle();
    chk("R4 both commands issued", n_cmd, 3);
    chk("R4 second opcode", {24'h0, last_cmd}, 32'h30);

    // R5 data write
    bus_wr(S_DATA, 32'h0000_00C3, s);
    wait_idle();
    chk("R5 data write count", n_wd, 1);
    chk("R5 data write byte", {24'h0, last_wd}, 32'hC3);

    // R6 data reads
    nand_dq_in = 8'hA5;
    bus_rd(S_DATA, 1'b1, 8'h3C, r);
    chk("R6 byte sampled at read strobe rise", r, 32'hA5);
    nand_dq_in = 8'h5A;
    bus_rd(S_DATA, 1'b0, 8'h00, r);
    chk("R6 second read byte", r, 32'h5A);

    // R7 ready flag
    @(negedge clk); nand_rb = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 falling ready does not set flag", {31'h0, ready_irq}, 32'h0);
    nand_rb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 flag set on ready", {31'h0, ready_irq}, 32'h1);
    bus_rd(S_FLAG, 1'b0, 8'h00, r);
    chk("R7 flag register bit 10", r, 32'h0000_0400);
    @(negedge clk); nand_rb = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 flag sticky after busy", {31'h0, ready_irq}, 32'h1);

    // R8 write-one-to-clear
    bus_wr(S_FLAG, 32'h0, s);
    chk("R8 writing zero keeps flag", {31'h0, ready_irq}, 32'h1);
    bus_wr(S_FLAG, 32'h0000_0400, s);
    chk("R8 writing one clears flag", {31'h0, ready_irq}, 32'h0);

    // R11 soft reset aborts a cycle and closes the address sequence
    wait_idle();
    bus_wr(S_ADDR, 32'h0000_0001, s);
    bus_wr(S_CMD, 32'h70, s);
    bus_wr(S_CTRL, 32'h1, s);
    @(negedge clk);
    chk("R11 strobes idle after soft reset",
        {28'h0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hC);
    bus_rd(S_ADDR, 1'b0, 8'h00, r);
    chk("R11 address phase cleared", r, 32'h0);
    chk("R11 chip select unchanged", {31'h0, nand_ce_n}, 32'h0);
    bus_wr(S_CMD, 32'h71, s);
    wait_idle();
    chk("R11 command after soft reset", {24'h0, last_cmd}, 32'h71);

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule